// File: doc/BRIEF.md
# Packed Pixel Line Unpacker

This block sits between the frame-buffer fetch path and the palette or colour stage of a display pipeline. It takes the 32-bit words that hold one scan line and returns one pixel for each accepted handshake. A three-bit depth code sets the pixel size, from 1 to 32 bits. Two ordering flags set the order in which pixels are taken from each word. A channel-swap flag exchanges the red and blue channels of direct-colour pixels.

At 1, 2, 4 and 8 bits per pixel the output is a palette index with zeros above it. At 16 and 32 bits per pixel the output is a 24-bit direct colour. The block counts pixels against the programmed line width and marks the last one with an end-of-line strobe. Whatever remains of the current word after that pixel is thrown away, so each new line starts on a fresh word. The configuration inputs are read directly and must not change while a line is in flight.

Top module: `pixel_line_unpacker`

## Requirements
- R1: Depth code n (0..5) selects 2^n bits per pixel (1, 2, 4, 8, 16, 32); codes 6 and 7 behave exactly like code 3 (8 bits).
- R2: With both ordering flags clear, bytes are taken from word bits [7:0] upward, and sub-byte pixels are taken from the least significant bits of each byte first (pixel k sits at bit offset k*bpp).
- R3: With only the pixel-order flag set, bytes are still taken from bits [7:0] upward, but sub-byte pixels are taken from the most significant bits of each byte first. At 8, 16 and 32 bits per pixel this flag has no effect.
- R4: With the byte-order flag set, pixels are taken from the top of the word downward (pixel k occupies bits [31-k*bpp -: bpp]). This holds at every depth. When both ordering flags are set, the byte-order flag wins.
- R5: At depths below 16 bits, pix_data carries the index in its low bits with zeros above, and pix_direct is 0. At codes 4 and 5, pix_direct is 1.
- R6: At 16 bits per pixel, pixel bits [4:0], [10:5] and [15:11] become the output bytes c0, c1 and c2, shifted left by 3, 2 and 3. At 32 bits per pixel, c0, c1 and c2 are pixel bits [7:0], [15:8] and [23:16], and bits [31:24] are dropped. With swap_rb = 0, pix_data = {c2, c1, c0}.
- R7: With swap_rb = 1, direct-colour output is {c0, c1, c2}. Palette indices are unaffected by swap_rb.
- R8: pix_eol is high together with the last pixel of the line. The unused remainder of that word is discarded, and the next line begins with the next accepted word.
- R9: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data holds its value. Every pixel is delivered exactly once.
- R10: After reset, pix_valid is 0 and word_ready is 1.
- R11: Each line delivers exactly line_width pixels. A line may span several words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_width | input | WIDTH_W | Pixels per line, at least 1 |
| depth_code | input | 3 | Bits-per-pixel selector |
| swap_rb | input | 1 | Exchange red and blue channels of direct colour |
| be_byte | input | 1 | Take pixels from the top of each word downward |
| be_pix | input | 1 | Take sub-byte pixels from the top of each byte first |
| word_valid | input | 1 | A source word is offered |
| word_data | input | 32 | Source word |
| word_ready | output | 1 | The block accepts word_data this cycle |
| pix_valid | output | 1 | A pixel is offered |
| pix_ready | input | 1 | The consumer takes the pixel |
| pix_data | output | 24 | Palette index (zero-extended) or direct colour |
| pix_direct | output | 1 | 1 means pix_data is a direct colour |
| pix_eol | output | 1 | Marks the last pixel of a line |

## Verification
The assertions assume that line_width is at least 1. They also assume that depth_code, the ordering flags, swap_rb and line_width stay constant whenever a pixel is pending. The hold and count checks rely on both assumptions. The bench changes configuration only after a line has drained completely and the block is idle, and it never programs a width of zero. Stalls on pix_ready come from a pseudo-random pattern during the multi-word lines. Every other line runs with pix_ready held high.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;

    // Depth code n maps to log2(bits per pixel) = n; unused codes fall back to 8 bits.
    function automatic logic [2:0] depth_lg(input logic [2:0] code);
        return (code > 3'd5) ? 3'd3 : code;
    endfunction

endpackage

// File: rtl/pxu_slot_pick.sv
module pxu_slot_pick
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        slot,
    input  logic [2:0]        lg,
    input  logic              be_byte,
    input  logic              be_pix,
    output logic [PIX_W-1:0]  raw
);

    logic [5:0]        bpp;
    logic [5:0]        le_off;
    logic [5:0]        off;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        bpp    = 6'd1 << lg;
        le_off = {1'b0, slot} << lg;
        if (be_byte) begin
            off = 6'd32 - bpp - le_off;
        end else if (be_pix && lg < 3'd3) begin
            off = {le_off[5:3], le_off[2:0] ^ 3'(6'd8 - bpp)};
        end else begin
            off = le_off;
        end
        mask    = (lg >= 3'd5) ? '1 : ((32'd1 << bpp) - 32'd1);
        shifted = (word >> off) & mask;
        raw     = shifted[PIX_W-1:0];
    end

    // R1
    always_comb begin
        offset_range_chk: assert ((7'(off) + 7'(bpp)) <= 7'd32);
    end

endmodule

// File: rtl/pxu_color_fmt.sv
module pxu_color_fmt
    import pxu_pkg::*;
(
    input  logic [PIX_W-1:0] raw,
    input  logic [2:0]       lg,
    input  logic             swap_rb,
    output logic [PIX_W-1:0] data,
    output logic             direct
);

    logic [7:0] c0, c1, c2;

    always_comb begin
        case (lg)
            3'd4: begin
                c0 = {raw[4:0], 3'b000};
                c1 = {raw[10:5], 2'b00};
                c2 = {raw[15:11], 3'b000};
            end
            3'd5: begin
                c0 = raw[7:0];
                c1 = raw[15:8];
                c2 = raw[23:16];
            end
            default: begin
                c0 = raw[7:0];
                c1 = 8'd0;
                c2 = 8'd0;
            end
        endcase
        direct = (lg >= 3'd4);
        if (direct) begin
            data = swap_rb ? {c0, c1, c2} : {c2, c1, c0};
        end else begin
            data = {16'd0, raw[7:0]};
        end
    end

endmodule

// File: rtl/pixel_line_unpacker.sv
module pixel_line_unpacker
    import pxu_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] line_width,
    input  logic [2:0]         depth_code,
    input  logic               swap_rb,
    input  logic               be_byte,
    input  logic               be_pix,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    output logic               word_ready,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [PIX_W-1:0]   pix_data,
    output logic               pix_direct,
    output logic               pix_eol
);

    typedef struct packed {
        logic               full;
        logic [WORD_W-1:0]  word;
        logic [4:0]         slot;
        logic [WIDTH_W-1:0] cnt;
    } unpack_st_t;

    unpack_st_t st_d, st_q;

    logic [2:0]       lg;
    logic [4:0]       last_slot;
    logic             slot_end;
    logic             line_end;
    logic             take;
    logic             release_word;
    logic [PIX_W-1:0] raw;

    pxu_slot_pick u_pick (
        .word    (st_q.word),
        .slot    (st_q.slot),
        .lg      (lg),
        .be_byte (be_byte),
        .be_pix  (be_pix),
        .raw     (raw)
    );

    pxu_color_fmt u_fmt (
        .raw     (raw),
        .lg      (lg),
        .swap_rb (swap_rb),
        .data    (pix_data),
        .direct  (pix_direct)
    );

    always_comb begin
        lg           = depth_lg(depth_code);
        last_slot    = 5'd31 >> lg;
        slot_end     = (st_q.slot == last_slot);
        line_end     = (st_q.cnt == line_width - WIDTH_W'(1));
        pix_valid    = st_q.full;
        pix_eol      = st_q.full && line_end;
        take         = pix_valid && pix_ready;
        release_word = take && (slot_end || line_end);
        word_ready   = !st_q.full || release_word;

        st_d = st_q;
        if (take) begin
            st_d.slot = st_q.slot + 5'd1;
            st_d.cnt  = line_end ? '0 : st_q.cnt + WIDTH_W'(1);
        end
        if (release_word) begin
            st_d.full = 1'b0;
            st_d.slot = 5'd0;
        end
        if (word_valid && word_ready) begin
            st_d.full = 1'b1;
            st_d.word = word_data;
            st_d.slot = 5'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

    // R5
    direct_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_direct == (depth_code == 3'd4 || depth_code == 3'd5)));

    // R8
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && pix_eol) |=> (st_q.cnt == '0));

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (st_q.cnt < line_width));

endmodule

// File: tb/tb_pixel_line_unpacker.sv
module tb_pixel_line_unpacker;

    localparam int CLK_P   = 10;
    localparam int WIDTH_W = 12;

    typedef struct packed {
        logic [31:0] w;
        logic [2:0]  d;
        logic        bb;
        logic        bp;
        logic        sw;
        logic [5:0]  width;
        logic [4:0]  idx;
        logic [23:0] exp;
        logic        dir;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 3'd3, 1'b0, 1'b0, 1'b0, 6'd4,  5'd0, 24'h000078, 1'b0, 4'd2},  // R2 8bpp
        '{32'h12345678, 3'd3, 1'b1, 1'b0, 1'b0, 6'd4,  5'd0, 24'h000012, 1'b0, 4'd4},  // R4
        '{32'h12345678, 3'd3, 1'b1, 1'b0, 1'b0, 6'd4,  5'd3, 24'h000078, 1'b0, 4'd4},  // R4
        '{32'h12345678, 3'd0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd3, 24'h000001, 1'b0, 4'd2},  // R2 1bpp
        '{32'h12345678, 3'd0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0, 24'h000000, 1'b0, 4'd2},  // R2
        '{32'h12345678, 3'd0, 1'b0, 1'b1, 1'b0, 6'd32, 5'd1, 24'h000001, 1'b0, 4'd3},  // R3
        '{32'h12345678, 3'd0, 1'b1, 1'b0, 1'b0, 6'd32, 5'd3, 24'h000001, 1'b0, 4'd4},  // R4
        '{32'h12345678, 3'd1, 1'b0, 1'b0, 1'b0, 6'd16, 5'd1, 24'h000002, 1'b0, 4'd2},  // R2 2bpp
        '{32'h12345678, 3'd1, 1'b0, 1'b1, 1'b0, 6'd16, 5'd0, 24'h000001, 1'b0, 4'd3},  // R3
        '{32'h12345678, 3'd1, 1'b1, 1'b0, 1'b0, 6'd16, 5'd3, 24'h000002, 1'b0, 4'd4},  // R4
        '{32'h12345678, 3'd2, 1'b0, 1'b0, 1'b0, 6'd8,  5'd7, 24'h000001, 1'b0, 4'd2},  // R2 4bpp
        '{32'h12345678, 3'd2, 1'b0, 1'b1, 1'b0, 6'd8,  5'd2, 24'h000005, 1'b0, 4'd3},  // R3
        '{32'h12345678, 3'd2, 1'b1, 1'b1, 1'b0, 6'd8,  5'd0, 24'h000001, 1'b0, 4'd4},  // R4 both flags
        '{32'h12345678, 3'd2, 1'b1, 1'b0, 1'b0, 6'd8,  5'd7, 24'h000008, 1'b0, 4'd4},  // R4
        '{32'hAA112233, 3'd5, 1'b0, 1'b0, 1'b0, 6'd1,  5'd0, 24'h112233, 1'b1, 4'd6},  // R6 32bpp
        '{32'hAA112233, 3'd5, 1'b0, 1'b0, 1'b1, 6'd1,  5'd0, 24'h332211, 1'b1, 4'd7},  // R7
        '{32'h123407FF, 3'd4, 1'b0, 1'b0, 1'b0, 6'd2,  5'd0, 24'h00FCF8, 1'b1, 4'd6},  // R6 16bpp
        '{32'h123407FF, 3'd4, 1'b0, 1'b0, 1'b1, 6'd2,  5'd0, 24'hF8FC00, 1'b1, 4'd7},  // R7
        '{32'h123407FF, 3'd4, 1'b0, 1'b0, 1'b0, 6'd2,  5'd1, 24'h1044A0, 1'b1, 4'd6},  // R6
        '{32'h123407FF, 3'd4, 1'b1, 1'b0, 1'b0, 6'd2,  5'd0, 24'h1044A0, 1'b1, 4'd4},  // R4 16bpp
        '{32'h123407FF, 3'd4, 1'b0, 1'b1, 1'b0, 6'd2,  5'd0, 24'h00FCF8, 1'b1, 4'd3},  // R3 no effect
        '{32'h12345678, 3'd3, 1'b0, 1'b0, 1'b1, 6'd4,  5'd0, 24'h000078, 1'b0, 4'd7},  // R7 index kept
        '{32'h12345678, 3'd6, 1'b0, 1'b0, 1'b0, 6'd4,  5'd1, 24'h000056, 1'b0, 4'd1},  // R1 code 6
        '{32'h12345678, 3'd7, 1'b0, 1'b1, 1'b0, 6'd4,  5'd0, 24'h000078, 1'b0, 4'd1},  // R1 code 7, R3
        '{32'h12345678, 3'd3, 1'b0, 1'b1, 1'b0, 6'd4,  5'd2, 24'h000034, 1'b0, 4'd3}   // R3 8bpp
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [WIDTH_W-1:0] line_width = WIDTH_W'(4);
    logic [2:0]         depth_code = 3'd3;
    logic               swap_rb = 1'b0;
    logic               be_byte = 1'b0;
    logic               be_pix = 1'b0;
    logic               word_valid = 1'b0;
    logic [31:0]        word_data = '0;
    logic               word_ready;
    logic               pix_valid;
    logic               pix_ready = 1'b1;
    logic [23:0]        pix_data;
    logic               pix_direct;
    logic               pix_eol;

    int checks = 0;
    int fails  = 0;
    int cap_n  = 0;
    logic        stall_mode = 1'b0;
    logic [23:0] cap_d [64];
    logic        cap_e [64];
    logic        cap_r [64];

    pixel_line_unpacker #(.WIDTH_W(WIDTH_W)) dut (
        .clk, .rst_n, .line_width, .depth_code, .swap_rb, .be_byte, .be_pix,
        .word_valid, .word_data, .word_ready, .pix_valid, .pix_ready,
        .pix_data, .pix_direct, .pix_eol
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        pix_ready = !stall_mode || (($urandom % 3) != 0);
    end

    always @(negedge clk) begin
        if (rst_n && pix_valid && pix_ready && cap_n < 64) begin
            cap_d[cap_n] = pix_data;
            cap_e[cap_n] = pix_eol;
            cap_r[cap_n] = pix_direct;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic send_word(input logic [31:0] w);
        @(posedge clk);
        #1;
        word_valid = 1'b1;
        word_data  = w;
        do @(negedge clk); while (!word_ready);
        @(posedge clk);
        #1;
        word_valid = 1'b0;
    endtask

    task automatic wait_pixels(input int n);
        for (int t = 0; t < 400 && cap_n < n; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pix_valid == 1'b0, "R10 pix_valid", 32'(pix_valid), 0);
        check(word_ready == 1'b1, "R10 word_ready", 32'(word_ready), 1);

        for (int v = 0; v < NV; v++) begin
            depth_code = VECS[v].d;
            be_byte    = VECS[v].bb;
            be_pix     = VECS[v].bp;
            swap_rb    = VECS[v].sw;
            line_width = WIDTH_W'(VECS[v].width);
            cap_n      = 0;
            send_word(VECS[v].w);
            wait_pixels(int'(VECS[v].width));
            // R11 pixel count per line
            check(cap_n == int'(VECS[v].width), "R11 count", 32'(cap_n), 32'(VECS[v].width));
            check(cap_d[VECS[v].idx] == VECS[v].exp, $sformatf("R%0d vec%0d data", VECS[v].req, v),
                  32'(cap_d[VECS[v].idx]), 32'(VECS[v].exp));
            // R5 direct flag
            check(cap_r[VECS[v].idx] == VECS[v].dir, "R5 direct", 32'(cap_r[VECS[v].idx]),
                  32'(VECS[v].dir));
            // R8 eol on last pixel only
            check(cap_e[VECS[v].width - 1] == 1'b1 &&
                  (VECS[v].width == 1 || cap_e[0] == 1'b0), "R8 eol",
                  32'(cap_e[VECS[v].width - 1]), 1);
        end

        // R8, R9, R11: two lines of 6 pixels at 8bpp spanning words, with stalls
        depth_code = 3'd3; be_byte = 0; be_pix = 0; swap_rb = 0;
        line_width = WIDTH_W'(6);
        cap_n = 0;
        stall_mode = 1'b1;
        send_word(32'h03020100);
        send_word(32'h07060504);
        send_word(32'h0B0A0908);
        send_word(32'h0F0E0D0C);
        wait_pixels(12);
        stall_mode = 1'b0;
        check(cap_n == 12, "R11 two-line count", 32'(cap_n), 12);
        for (int i = 0; i < 12; i++) begin
            logic [23:0] e;
            e = (i < 6) ? 24'(i) : 24'(i + 2);
            check(cap_d[i] == e, "R9 R8 stalled sequence", 32'(cap_d[i]), 32'(e));
            check(cap_e[i] == (i == 5 || i == 11), "R8 eol position", 32'(cap_e[i]),
                  32'(i == 5 || i == 11));
        end

        // R8: width-1 lines at 1bpp; remainder of each word discarded
        depth_code = 3'd0;
        line_width = WIDTH_W'(1);
        cap_n = 0;
        send_word(32'hFFFFFFFF);
        send_word(32'h00000000);
        wait_pixels(2);
        check(cap_n == 2, "R8 width1 count", 32'(cap_n), 2);
        check(cap_d[0] == 24'd1 && cap_e[0], "R8 width1 first", 32'(cap_d[0]), 1);
        check(cap_d[1] == 24'd0 && cap_e[1], "R8 width1 second", 32'(cap_d[1]), 0);
        @(negedge clk);
        check(pix_valid == 1'b0 && word_ready == 1'b1, "R8 idle after line",
              32'({pix_valid, word_ready}), 32'h1);

        finish_up();
    end

endmodule